// File: doc/BRIEF.md
# Sine/Cosine Octant Reduction Front End

This block is the integer front end of a generator of (cosine, sine) pairs around the full circle. A phase register walks by a programmable step every time a sample is issued. Each issued phase is cut into a 3-bit octant number and a fraction. The fraction is reflected in odd octants so that an external evaluator only ever has to approximate the first octant. The same phase feeds several lanes: lane k works on the phase shifted left by k, so lane 1 runs at twice the angle of lane 0.

For every issue the block derives three flags per lane: a swap flag, a cosine-negate flag and a sine-negate flag. It holds them in a delay line whose depth equals the evaluator latency. When the evaluator returns its raw single-precision pair, the block exchanges the two words if the swap flag is set. It then flips bit 31 of each word according to its negate flag and registers the corrected IEEE-754 (cos, sin) pair. A returned result with no issue tag waiting for it raises a sticky error flag.

Top module: `sincos_octant_front`

## Requirements
- R1: While `start_i` is high the phase register loads `w0_i` at the next clock edge. `iss_vld_o` is low in that cycle, even when `run_i` is high.
- R2: `iss_vld_o` follows `run_i` whenever `start_i` is low. The phase advances by `step_i` (modulo 2^PHASE_W) after each issue and holds in cycles without an issue. Lane k uses the phase shifted left by k bits, dropping bits above PHASE_W-1.
- R3: The octant j is the top 3 bits of the lane phase and x is the remaining FRAC_W bits. `iss_frac_o` for a lane is x when j is even and 2^FRAC_W − x when j is odd, so x = 0 in an odd octant gives exactly 2^FRAC_W.
- R4: The returned cosine and sine words of a lane are exchanged when the issue octant is 1, 2, 5 or 6, and passed straight through for octants 0, 3, 4 and 7.
- R5: Bit 31 of the cosine output is inverted for issue octants 2 through 5. Bit 31 of the sine output is inverted for octants 4 through 7. Bits 30:0 are never altered.
- R6: When `res_vld_i` arrives EVAL_LAT cycles after an issue, the corrected pair appears on `out_cos_o`/`out_sin_o` with `out_vld_o` high one cycle later. It uses the flags of that issue.
- R7: A `res_vld_i` pulse with no issue exactly EVAL_LAT cycles earlier produces no output. It sets `err_o` from the next cycle on, and only a `start_i` or a reset clears it.
- R8: After reset the phase is zero, and `iss_vld_o`, `out_vld_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load the phase with `w0_i` |
| w0_i | input | PHASE_W | Start phase |
| step_i | input | PHASE_W | Phase increment per issue |
| run_i | input | 1 | Issue one sample this cycle |
| iss_vld_o | output | 1 | Fraction outputs carry an issue |
| iss_frac_o | output | LANES×(FRAC_W+1) | Reflected fraction per lane, lane 0 in the low slice |
| res_vld_i | input | 1 | Evaluator result valid |
| res_cos_i | input | LANES×32 | Raw first-octant cosine per lane |
| res_sin_i | input | LANES×32 | Raw first-octant sine per lane |
| out_vld_o | output | 1 | Corrected pair valid |
| out_cos_o | output | LANES×32 | Corrected cosine per lane |
| out_sin_o | output | LANES×32 | Corrected sine per lane |
| err_o | output | 1 | Sticky error: result without a matching issue |

## Verification
The fraction of an issue is combinational, so it is sampled in the issue cycle itself, a nanosecond after the inputs are driven at the falling edge. The bench's evaluator model returns each result exactly EVAL_LAT edges after its issue. It keeps the expected corrected pair in a matching pipeline one stage deeper, so every falling edge compares `out_vld_o` and the data against the issue made EVAL_LAT+1 cycles earlier. An orphan result is injected when no issue is in flight, and `err_o` is checked at the falling edge right after the edge that captures it.

// File: rtl/sco_pkg.sv
package sco_pkg;
  // A full turn is split into eight octants.
  localparam int OCT_W = 3;

  typedef struct packed {
    logic swap;   // exchange cosine and sine words
    logic cneg;   // invert sign of the cosine word
    logic sneg;   // invert sign of the sine word
  } oct_flags_t;
endpackage

// File: rtl/sco_phase_gen.sv
module sco_phase_gen #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] w0_i,
  input  logic [PHASE_W-1:0] step_i,
  input  logic               run_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] w_q, w_d;
  logic               w_en;

  always_comb begin
    w_en = start_i | run_i;
    w_d  = w_q;
    if (start_i)    w_d = w0_i;
    else if (run_i) w_d = w_q + step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    w_q <= '0;
    else if (w_en) w_q <= w_d;
  end

  assign phase_o = w_q;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> w_q == $past(w0_i));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !run_i) |=> $stable(w_q));
endmodule

// File: rtl/sco_octant_split.sv
module sco_octant_split
  import sco_pkg::*;
#(
  parameter int PHASE_W = 32,
  localparam int FRAC_W = PHASE_W - OCT_W
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [FRAC_W:0]    frac_o,
  output oct_flags_t         flags_o
);
  logic [OCT_W-1:0]  oct;
  logic [OCT_W-1:0]  oct_p1, oct_p2;
  logic [FRAC_W-1:0] x;

  always_comb begin
    oct    = phase_i[PHASE_W-1 -: OCT_W];
    x      = phase_i[FRAC_W-1:0];
    oct_p1 = oct + OCT_W'(1);
    oct_p2 = oct + OCT_W'(2);
    if (oct[0]) frac_o = {1'b1, {FRAC_W{1'b0}}} - {1'b0, x};
    else        frac_o = {1'b0, x};
    flags_o.swap = oct_p1[1];
    flags_o.cneg = oct_p2[2];
    flags_o.sneg = oct[2];
  end

  // R3: a reflected fraction never exceeds one full octant.
  always_comb begin
    p_frac_range_r3: assert (frac_o <= {1'b1, {FRAC_W{1'b0}}});
  end
endmodule

// File: rtl/sco_flag_delay.sv
module sco_flag_delay
  import sco_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_vld_i,
  input  oct_flags_t [LANES-1:0] push_flags_i,
  output logic                   tag_vld_o,
  output oct_flags_t [LANES-1:0] tag_flags_o
);
  typedef struct packed {
    logic                   vld;
    oct_flags_t [LANES-1:0] flg;
  } stage_t;

  stage_t stg_q [DEPTH];
  stage_t stg_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      assign stg_d[i] = '{vld: push_vld_i, flg: push_flags_i};
    end else begin : g_body
      assign stg_d[i] = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d[i];
    end
  end

  assign tag_vld_o   = stg_q[DEPTH-1].vld;
  assign tag_flags_o = stg_q[DEPTH-1].flg;
endmodule

// File: rtl/sco_sign_fix.sv
module sco_sign_fix
  import sco_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   res_vld_i,
  input  logic [LANES-1:0][31:0] res_cos_i,
  input  logic [LANES-1:0][31:0] res_sin_i,
  input  logic                   tag_vld_i,
  input  oct_flags_t [LANES-1:0] tag_flags_i,
  output logic                   out_vld_o,
  output logic [LANES-1:0][31:0] out_cos_o,
  output logic [LANES-1:0][31:0] out_sin_o,
  output logic                   err_o
);
  logic [LANES-1:0][31:0] fix_c, fix_s;
  logic                   vld_d, err_d, dat_en;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] pick_c, pick_s;
    assign pick_c   = tag_flags_i[k].swap ? res_sin_i[k] : res_cos_i[k];
    assign pick_s   = tag_flags_i[k].swap ? res_cos_i[k] : res_sin_i[k];
    assign fix_c[k] = {pick_c[31] ^ tag_flags_i[k].cneg, pick_c[30:0]};
    assign fix_s[k] = {pick_s[31] ^ tag_flags_i[k].sneg, pick_s[30:0]};

    p_mag_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> (out_cos_o[k][30:0] == $past(res_cos_i[k][30:0]) ||
                     out_cos_o[k][30:0] == $past(res_sin_i[k][30:0])));
  end

  always_comb begin
    dat_en = res_vld_i & tag_vld_i;
    vld_d  = dat_en;
    err_d  = clr_i ? 1'b0 : (err_o | (res_vld_i & ~tag_vld_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      out_vld_o <= vld_d;
      err_o     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cos_o <= '0;
      out_sin_o <= '0;
    end else if (dat_en) begin
      out_cos_o <= fix_c;
      out_sin_o <= fix_s;
    end
  end

  p_orphan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_i && !tag_vld_i && !clr_i) |=> (err_o && !out_vld_o));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/sincos_octant_front.sv
module sincos_octant_front
  import sco_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int LANES    = 2,
  parameter int EVAL_LAT = 4,
  localparam int FRAC_W  = PHASE_W - OCT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [PHASE_W-1:0]         w0_i,
  input  logic [PHASE_W-1:0]         step_i,
  input  logic                       run_i,
  output logic                       iss_vld_o,
  output logic [LANES-1:0][FRAC_W:0] iss_frac_o,
  input  logic                       res_vld_i,
  input  logic [LANES-1:0][31:0]     res_cos_i,
  input  logic [LANES-1:0][31:0]     res_sin_i,
  output logic                       out_vld_o,
  output logic [LANES-1:0][31:0]     out_cos_o,
  output logic [LANES-1:0][31:0]     out_sin_o,
  output logic                       err_o
);
  logic [1:0]             rsync_q;
  logic                   rst_core_n;
  logic [PHASE_W-1:0]     phase;
  logic                   issue;
  oct_flags_t [LANES-1:0] iss_flags;
  logic                   tag_vld;
  oct_flags_t [LANES-1:0] tag_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign issue     = run_i & ~start_i & rst_core_n;
  assign iss_vld_o = issue;

  sco_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i), .w0_i(w0_i),
    .step_i(step_i), .run_i(issue), .phase_o(phase));

  for (genvar k = 0; k < LANES; k++) begin : g_split
    logic [PHASE_W-1:0] lane_phase;
    assign lane_phase = phase << k;
    sco_octant_split #(.PHASE_W(PHASE_W)) u_split (
      .phase_i(lane_phase), .frac_o(iss_frac_o[k]), .flags_o(iss_flags[k]));
  end

  sco_flag_delay #(.LANES(LANES), .DEPTH(EVAL_LAT)) u_delay (
    .clk(clk), .rst_n(rst_core_n), .push_vld_i(issue), .push_flags_i(iss_flags),
    .tag_vld_o(tag_vld), .tag_flags_o(tag_flags));

  sco_sign_fix #(.LANES(LANES)) u_fix (
    .clk(clk), .rst_n(rst_core_n), .clr_i(start_i), .res_vld_i(res_vld_i),
    .res_cos_i(res_cos_i), .res_sin_i(res_sin_i), .tag_vld_i(tag_vld),
    .tag_flags_i(tag_flags), .out_vld_o(out_vld_o), .out_cos_o(out_cos_o),
    .out_sin_o(out_sin_o), .err_o(err_o));

  p_out_needs_res_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_vld_o |-> $past(res_vld_i));
  p_no_issue_on_start_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_i |-> !iss_vld_o);
endmodule

// File: tb/sincos_octant_front_tb_top.sv
`timescale 1ns/1ps
module sincos_octant_front_tb_top;
  localparam int PW  = 32;
  localparam int L   = 2;
  localparam int LAT = 4;
  localparam int FW  = PW - 3;
  localparam int NV  = 6;
  localparam int NI  = 8;
  // {w0, step}
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_1000, 32'h2000_0000},
    {32'h2000_0000, 32'h2000_0000},
    {32'hF000_0000, 32'h1234_5678},
    {32'h1FFF_FFFF, 32'h0000_0001},
    {32'h8765_4321, 32'h0000_0000},
    {32'h0000_0000, 32'hE000_0001}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, run_i = 1'b0, inj = 1'b0;
  logic [PW-1:0] w0_i = '0, step_i = '0;
  logic iss_vld_o, res_vld_i, out_vld_o, err_o;
  logic [L-1:0][FW:0] iss_frac_o;
  logic [L-1:0][31:0] res_cos_i, res_sin_i, out_cos_o, out_sin_o;

  int checks = 0, fails = 0;
  logic chk_en = 1'b0;
  logic [PW-1:0] m_w = '0;
  int cnt = 0;
  logic [L-1:0][31:0] iss_rc, iss_rs, iss_ec, iss_es;
  logic pv [LAT+1];
  logic [L-1:0][31:0] prc [LAT+1], prs [LAT+1], pec [LAT+1], pes [LAT+1];

  always #10 clk = ~clk;

  sincos_octant_front #(.PHASE_W(PW), .LANES(L), .EVAL_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .w0_i(w0_i), .step_i(step_i),
    .run_i(run_i), .iss_vld_o(iss_vld_o), .iss_frac_o(iss_frac_o),
    .res_vld_i(res_vld_i), .res_cos_i(res_cos_i), .res_sin_i(res_sin_i),
    .out_vld_o(out_vld_o), .out_cos_o(out_cos_o), .out_sin_o(out_sin_o), .err_o(err_o));

  // Evaluator model and expected-result pipeline.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAT; i++) pv[i] <= 1'b0;
    end else begin
      pv[0] <= run_i && !start_i;
      prc[0] <= iss_rc; prs[0] <= iss_rs; pec[0] <= iss_ec; pes[0] <= iss_es;
      for (int i = 1; i <= LAT; i++) begin
        pv[i] <= pv[i-1]; prc[i] <= prc[i-1]; prs[i] <= prs[i-1];
        pec[i] <= pec[i-1]; pes[i] <= pes[i-1];
      end
    end
  end
  assign res_vld_i = pv[LAT-1] | inj;
  assign res_cos_i = prc[LAT-1];
  assign res_sin_i = prs[LAT-1];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R6: output compared one cycle after the evaluator returns.
  always @(negedge clk) begin
    if (chk_en && (pv[LAT] || out_vld_o)) begin
      chk(out_vld_o == pv[LAT], "R6 out_vld", 64'(out_vld_o), 64'(pv[LAT]));
      if (pv[LAT]) begin
        for (int k = 0; k < L; k++) begin
          chk(out_cos_o[k] == pec[LAT][k], "R4/R5 cos", 64'(out_cos_o[k]), 64'(pec[LAT][k]));
          chk(out_sin_o[k] == pes[LAT][k], "R4/R5 sin", 64'(out_sin_o[k]), 64'(pes[LAT][k]));
        end
      end
    end
  end

  function automatic logic [FW:0] exp_frac(input logic [PW-1:0] ph);
    logic [2:0] j = ph[PW-1 -: 3];
    logic [FW-1:0] x = ph[FW-1:0];
    return j[0] ? ((FW+1)'(1) << FW) - {1'b0, x} : {1'b0, x};
  endfunction

  task automatic issue_one(input int vi);
    @(negedge clk);
    start_i = 1'b0; run_i = 1'b1;
    for (int k = 0; k < L; k++) begin
      logic [PW-1:0] ph = m_w << k;
      logic [2:0] j = ph[PW-1 -: 3];
      bit sw = (j == 1 || j == 2 || j == 5 || j == 6);
      bit cn = (j >= 2 && j <= 5);
      bit sn = (j >= 4);
      logic [31:0] rc = {1'b0, 8'd126, 23'(cnt * 29 + k * 3)};
      logic [31:0] rs = {cnt[1], 8'd125, 23'(cnt * 7 + k + 1)};
      logic [31:0] ec = sw ? rs : rc;
      logic [31:0] es = sw ? rc : rs;
      iss_rc[k] = rc; iss_rs[k] = rs;
      iss_ec[k] = {ec[31] ^ cn, ec[30:0]};
      iss_es[k] = {es[31] ^ sn, es[30:0]};
    end
    #1;
    chk(iss_vld_o == 1'b1, "R2 iss_vld", 64'(iss_vld_o), 64'd1);
    for (int k = 0; k < L; k++)
      chk(iss_frac_o[k] == exp_frac(m_w << k), $sformatf("R3 frac lane%0d vec%0d", k, vi),
          64'(iss_frac_o[k]), 64'(exp_frac(m_w << k)));
    m_w = m_w + step_i;
    cnt++;
  endtask

  task automatic load(input logic [PW-1:0] w0, input logic [PW-1:0] st, input logic rn);
    @(negedge clk);
    start_i = 1'b1; run_i = rn; w0_i = w0; step_i = st;
    #1;
    chk(iss_vld_o == 1'b0, "R1 no issue on start", 64'(iss_vld_o), 64'd0);
    m_w = w0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0; run_i = 1'b0;
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    iss_rc = '0; iss_rs = '0; iss_ec = '0; iss_es = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(iss_vld_o == 1'b0, "R8 iss_vld", 64'(iss_vld_o), 64'd0);
    chk(out_vld_o == 1'b0, "R8 out_vld", 64'(out_vld_o), 64'd0);
    chk(err_o == 1'b0, "R8 err", 64'(err_o), 64'd0);
    chk(iss_frac_o[0] == '0, "R8 phase zero", 64'(iss_frac_o[0]), 64'd0);
    chk_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][63:32], VEC[v][31:0], v[0]);   // R1: odd vectors also hold run high on start
      for (int i = 0; i < NI; i++) begin
        issue_one(v);
        if (v[0]) idle(1);                        // R2: phase holds across bubbles
      end
      idle(LAT + 3);
    end

    // R7: orphan result sets sticky error, produces no output.
    @(negedge clk); inj = 1'b1;
    @(negedge clk); inj = 1'b0;
    chk(err_o == 1'b1, "R7 err set", 64'(err_o), 64'd1);
    chk(out_vld_o == 1'b0, "R7 no output", 64'(out_vld_o), 64'd0);
    idle(3);
    chk(err_o == 1'b1, "R7 err sticky", 64'(err_o), 64'd1);
    load(32'h4000_0000, 32'h0, 1'b0);
    @(negedge clk); start_i = 1'b0;
    chk(err_o == 1'b0, "R7 err cleared by start", 64'(err_o), 64'd0);
    // R3: octant 2 boundary, x = 0 even octant
    issue_one(99);
    idle(LAT + 3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule